// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Sequencer

This block turns one write request, taken from a synchronous valid/ready command port, into a complete strobe sequence for an asynchronous parallel flash device. When a request is taken, the address and data buses are loaded and the output driver is enabled. The chip-enable strobe falls first and the write-enable strobe follows. Write-enable is held low for the pulse time and is released first, and chip-enable follows after the data hold time. Every interval is a whole number of clock cycles. Each is derived at elaboration from a nanosecond figure and the clock period, rounded up.

Chip-enable always opens before write-enable and closes after it. Write-enable alone therefore marks where the effective pulse starts and ends. When the chip-enable lead is long enough, the pulse gets the shorter requirement that a leading chip-enable allows. The pulse is also kept long enough for the address and data to meet their setup time before the rising edge.

After reset is released, the block waits out a power-up recovery time before it accepts any command. After each pulse it waits out a recovery time. That time covers both the delay before a following read and the delay the flash may take before its ready/busy line reports busy. After that the block polls the ready/busy line. It reports completion with a one-cycle done pulse. If the line stays busy past a configurable limit, the done pulse comes with an error flag. A program-enable output stays high from acceptance until completion is known.

Top module: `flash_write_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, fb_ce_n and fb_we_n are 1, and fb_dq_oe, fb_prog_en, cmd_ready, wr_done and wr_err are 0.
- R2: After reset is released, cmd_ready stays 0 for RST_CYC = ceil(T_RST_NS/CLK_NS) clock edges (100 at defaults) and rises after them. Requests made meanwhile are ignored: fb_ce_n stays 1.
- R3: A request is taken on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready is 0 from the next cycle until the cycle in which wr_done is 1.
- R4: fb_ce_n falls SETUP_CYC cycles before fb_we_n falls (1 at defaults). It rises HOLD_CYC cycles after fb_we_n rises (1 at defaults). fb_we_n is never 0 while fb_ce_n is 1.
- R5: fb_we_n stays 0 for exactly PULSE_CYC cycles. PULSE_CYC is ceil((T_WP_NS - T_WP_RELIEF_NS)/CLK_NS) when SETUP_CYC*CLK_NS >= T_WP_RELIEF_NS, and ceil(T_WP_NS/CLK_NS) otherwise. It is raised if needed so that SETUP_CYC+PULSE_CYC covers ceil(T_DSU_NS/CLK_NS). At defaults it is 6.
- R6: While fb_ce_n is 0, fb_dq_oe is 1 and fb_addr/fb_dq are stable and equal to the address and data of the accepted request.
- R7: fb_sts is not looked at until RECOVER_CYC = max(ceil(T_WRR_NS/CLK_NS), ceil(T_STS_NS/CLK_NS)) cycles (9 at defaults) have passed since fb_ce_n rose. If fb_sts is 1 (ready) throughout, wr_done is seen RECOVER_CYC+1 cycles after the first cycle with fb_ce_n high.
- R8: fb_sts=1 means ready and 0 means busy. Once polling has begun, fb_sts going to 1 yields a one-cycle wr_done with wr_err=0 one cycle later. cmd_ready rises in that same cycle.
- R9: If fb_sts stays 0 for TIMEOUT_CYC polling cycles, wr_done and wr_err are both 1 for one cycle. The block then accepts the next request normally.
- R10: fb_prog_en is 1 from the cycle after acceptance through the cycle before wr_done, and 0 in the wr_done cycle.
- R11: A request presented while cmd_ready is 0 produces no strobe pulse and is not latched; exactly one write pulse occurs per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Write request present |
| cmd_ready | output | 1 | Sequencer can take a request |
| cmd_addr | input | ADDR_W | Request address |
| cmd_data | input | DATA_W | Request data word |
| fb_sts | input | 1 | Flash ready/busy status, 1 = ready |
| fb_ce_n | output | 1 | Flash chip-enable, active low |
| fb_we_n | output | 1 | Flash write-enable, active low |
| fb_addr | output | ADDR_W | Flash address bus |
| fb_dq | output | DATA_W | Flash data bus value |
| fb_dq_oe | output | 1 | Data bus driver enable |
| fb_prog_en | output | 1 | Program-enable, high until completion known |
| wr_done | output | 1 | One-cycle completion pulse |
| wr_err | output | 1 | Ready/busy timeout, with wr_done |

## Verification
The completion pulse and the timeout error can land in the same cycle, and the error must never appear without the pulse. The bench holds the ready/busy input low past the polling limit. It then expects done and error together, exactly TIMEOUT_CYC cycles after polling began, with cmd_ready rising in that cycle. A separate run keeps the status input ready all the time, so that an early "ready" lines up with the end of recovery. That run shows completion still waits for the full recovery count.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOVER,
        ST_WAITRDY
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe;
        logic prog;
    } strobe_t;

    // nanoseconds to clock cycles, rounded up
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fw_timer.sv
module fw_timer #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(INIT);
        else if (ld)
            cnt <= ld_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fw_strobe.sv
module fw_strobe
    import flash_wr_pkg::*;
(
    input  seq_state_t st,
    output strobe_t    so
);
    always_comb begin
        so.ce_n = 1'b1;
        so.we_n = 1'b1;
        so.oe   = 1'b0;
        so.prog = 1'b0;
        case (st)
            ST_SETUP, ST_HOLD: begin
                so.ce_n = 1'b0;
                so.oe   = 1'b1;
                so.prog = 1'b1;
            end
            ST_PULSE: begin
                so.ce_n = 1'b0;
                so.we_n = 1'b0;
                so.oe   = 1'b1;
                so.prog = 1'b1;
            end
            ST_RECOVER, ST_WAITRDY: so.prog = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_write_seq.sv
module flash_write_seq
    import flash_wr_pkg::*;
#(
    parameter int ADDR_W         = 22,
    parameter int DATA_W         = 16,
    parameter int CLK_NS         = 10,
    parameter int T_RST_NS       = 1000,
    parameter int T_CE_LEAD_NS   = 10,
    parameter int T_WP_NS        = 70,
    parameter int T_WP_RELIEF_NS = 10,
    parameter int T_DSU_NS       = 50,
    parameter int T_DH_NS        = 10,
    parameter int T_WRR_NS       = 35,
    parameter int T_STS_NS       = 90,
    parameter int TIMEOUT_CYC    = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              fb_sts,
    output logic              fb_ce_n,
    output logic              fb_we_n,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [DATA_W-1:0] fb_dq,
    output logic              fb_dq_oe,
    output logic              fb_prog_en,
    output logic              wr_done,
    output logic              wr_err
);
    localparam int SETUP_CYC   = max2(1, ns_to_cyc(T_CE_LEAD_NS, CLK_NS));
    localparam int WP_NEED_NS  = (SETUP_CYC * CLK_NS >= T_WP_RELIEF_NS) ?
                                 (T_WP_NS - T_WP_RELIEF_NS) : T_WP_NS;
    localparam int PULSE_CYC   = max2(max2(1, ns_to_cyc(WP_NEED_NS, CLK_NS)),
                                      ns_to_cyc(T_DSU_NS, CLK_NS) - SETUP_CYC);
    localparam int HOLD_CYC    = max2(1, ns_to_cyc(T_DH_NS, CLK_NS));
    localparam int RECOVER_CYC = max2(1, max2(ns_to_cyc(T_WRR_NS, CLK_NS),
                                              ns_to_cyc(T_STS_NS, CLK_NS)));
    localparam int RST_CYC     = max2(1, ns_to_cyc(T_RST_NS, CLK_NS));
    localparam int MAX_CYC     = max2(max2(max2(RST_CYC, RECOVER_CYC),
                                           max2(PULSE_CYC, SETUP_CYC)),
                                      max2(HOLD_CYC, max2(1, TIMEOUT_CYC)));
    localparam int CNT_W       = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(RECOVER_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TMO   = CNT_W'(max2(1, TIMEOUT_CYC) - 1);

    seq_state_t        state_q, state_d;
    logic              tmr_ld, tmr_zero, fin, timed_out;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q, err_q;
    strobe_t           strb;

    fw_timer #(.W(CNT_W), .INIT(RST_CYC - 1)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .ld     (tmr_ld),
        .ld_val (tmr_val),
        .zero   (tmr_zero)
    );

    fw_strobe u_strobe (
        .st (state_q),
        .so (strb)
    );

    assign cmd_ready = (state_q == ST_IDLE);

    always_comb begin
        state_d   = state_q;
        tmr_ld    = 1'b0;
        tmr_val   = '0;
        fin       = 1'b0;
        timed_out = 1'b0;
        case (state_q)
            ST_BOOT:
                if (tmr_zero) state_d = ST_IDLE;
            ST_IDLE:
                if (cmd_valid) begin
                    state_d = ST_SETUP;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_SETUP;
                end
            ST_SETUP:
                if (tmr_zero) begin
                    state_d = ST_PULSE;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_PULSE;
                end
            ST_PULSE:
                if (tmr_zero) begin
                    state_d = ST_HOLD;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_HOLD;
                end
            ST_HOLD:
                if (tmr_zero) begin
                    state_d = ST_RECOVER;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_REC;
                end
            ST_RECOVER:
                if (tmr_zero) begin
                    state_d = ST_WAITRDY;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_TMO;
                end
            ST_WAITRDY:
                if (fb_sts || tmr_zero) begin
                    state_d   = ST_IDLE;
                    fin       = 1'b1;
                    timed_out = !fb_sts;
                end
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            addr_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
            err_q   <= fin && timed_out;
            if (state_q == ST_IDLE && cmd_valid) begin
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
        end
    end

    assign fb_ce_n    = strb.ce_n;
    assign fb_we_n    = strb.we_n;
    assign fb_dq_oe   = strb.oe;
    assign fb_prog_en = strb.prog;
    assign fb_addr    = addr_q;
    assign fb_dq      = data_q;
    assign wr_done    = done_q;
    assign wr_err     = err_q;
endmodule

// File: rtl/fw_sva.sv
module fw_sva #(
    parameter int AW        = 22,
    parameter int DW        = 16,
    parameter int PULSE_CYC = 6,
    parameter int RST_CYC   = 100
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] dq,
    input logic          oe,
    input logic          prog,
    input logic          ready,
    input logic          done,
    input logic          err
);
    localparam int BW = $clog2(RST_CYC + 2) + 1;
    localparam int PW = $clog2(PULSE_CYC + 2) + 1;

    logic [BW-1:0] boot_cnt;
    logic [PW-1:0] wlow_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            boot_cnt <= '0;
        else if (boot_cnt < BW'(RST_CYC + 1))
            boot_cnt <= boot_cnt + 1'b1;
        if (rst || we_n)
            wlow_cnt <= '0;
        else if (wlow_cnt < PW'(PULSE_CYC + 1))
            wlow_cnt <= wlow_cnt + 1'b1;
    end

    p_boot_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> boot_cnt > BW'(RST_CYC));

    p_busy_noready_r3: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> !ready);

    p_we_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n);

    p_ce_lead_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> !$past(ce_n));

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> wlow_cnt == PW'(PULSE_CYC));

    p_bus_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !$past(ce_n)) |-> ($stable(addr) && $stable(dq) && oe));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    p_prog_cover_r10: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> prog);

    p_prog_drop_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !prog);
endmodule

bind flash_write_seq fw_sva #(
    .AW        (ADDR_W),
    .DW        (DATA_W),
    .PULSE_CYC (PULSE_CYC),
    .RST_CYC   (RST_CYC)
) u_sva (
    .clk   (clk),
    .rst   (rst),
    .ce_n  (fb_ce_n),
    .we_n  (fb_we_n),
    .addr  (fb_addr),
    .dq    (fb_dq),
    .oe    (fb_dq_oe),
    .prog  (fb_prog_en),
    .ready (cmd_ready),
    .done  (wr_done),
    .err   (wr_err)
);

// File: tb/flash_write_seq_test.sv
module flash_write_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int TMO = 64;

    function automatic int cyc(input int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction

    // expected values from the requirements
    localparam int E_RST   = cyc(1000);
    localparam int E_SETUP = 1;
    localparam int E_PULSE = cyc(70 - 10);
    localparam int E_HOLD  = 1;
    localparam int E_REC   = (cyc(35) > cyc(90)) ? cyc(35) : cyc(90);
    localparam int STS_BUSY = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic fb_sts = 1'b1;
    logic fb_ce_n, fb_we_n, fb_dq_oe, fb_prog_en, wr_done, wr_err;
    logic [AW-1:0] fb_addr;
    logic [DW-1:0] fb_dq;

    int checks = 0;
    int errors = 0;
    logic [AW+DW-1:0] sb_q[$];

    flash_write_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD),
                      .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .fb_sts(fb_sts),
        .fb_ce_n(fb_ce_n), .fb_we_n(fb_we_n), .fb_addr(fb_addr), .fb_dq(fb_dq),
        .fb_dq_oe(fb_dq_oe), .fb_prog_en(fb_prog_en),
        .wr_done(wr_done), .wr_err(wr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: strobe shape and scoreboard compare at the terminating edge
    logic prev_we = 1'b1, prev_ce = 1'b1, seen_we = 1'b0;
    int wlow = 0, clead = 0, ctrail = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!fb_ce_n && fb_we_n && !seen_we) clead++;
            if (!fb_we_n) begin
                wlow++;
                seen_we = 1'b1;
                chk(!fb_ce_n, "R4 we inside ce", fb_ce_n, 0);
            end
            if (!prev_we && fb_we_n) begin
                chk(wlow == E_PULSE, "R5 pulse width", wlow, E_PULSE);
                chk(clead == E_SETUP, "R4 ce lead", clead, E_SETUP);
                chk(fb_dq_oe, "R6 driver enable", fb_dq_oe, 1);
                if (sb_q.size() == 0)
                    chk(0, "R11 unexpected pulse", 1, 0);
                else begin
                    logic [AW+DW-1:0] e;
                    e = sb_q.pop_front();
                    chk({fb_addr, fb_dq} == e, "R6 bus value", {fb_addr, fb_dq}, e);
                end
                wlow = 0;
            end
            if (seen_we && !fb_ce_n && fb_we_n) ctrail++;
            if (!prev_ce && fb_ce_n) begin
                chk(ctrail == E_HOLD, "R4 ce trail", ctrail, E_HOLD);
                ctrail = 0; clead = 0; seen_we = 1'b0;
            end
            prev_we = fb_we_n;
            prev_ce = fb_ce_n;
        end
    end

    // mode 0: busy then ready; 1: ready throughout; 2: stuck busy
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int mode);
        int k = 0, s = -1, dn = -1;
        bit low_seen = 0;
        logic prog_prev = 1'b0;
        sb_q.push_back({a, d});
        cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        while (k < 5000) begin
            @(negedge clk);
            k++;
            if (k == 1) cmd_valid = 1'b0;
            if (k == 1) chk(!cmd_ready, "R3 ready drops", cmd_ready, 0);
            if (mode == 1 && k == 3) begin
                cmd_valid = 1'b1; cmd_data = ~d; cmd_addr = ~a;
            end
            if (!fb_ce_n) low_seen = 1;
            if (low_seen && fb_ce_n && s < 0) begin
                s = k;
                chk(!cmd_ready, "R3 busy in recovery", cmd_ready, 0);
                cmd_valid = 1'b0;
                if (mode != 1) fb_sts = 1'b0;
            end
            if (mode == 0 && s >= 0 && k == s + STS_BUSY) fb_sts = 1'b1;
            if (wr_done) begin
                dn = k;
                break;
            end
            prog_prev = fb_prog_en;
        end
        chk(dn > 0, "R8 done seen", dn, 1);
        chk(cmd_ready, "R8 ready with done", cmd_ready, 1);
        chk(prog_prev, "R10 prog high before done", prog_prev, 1);
        chk(!fb_prog_en, "R10 prog low at done", fb_prog_en, 0);
        if (mode == 0) begin
            chk(!wr_err, "R8 no error", wr_err, 0);
            chk(dn - s == STS_BUSY + 1, "R8 done delay", dn - s, STS_BUSY + 1);
        end else if (mode == 1) begin
            chk(!wr_err, "R7 no error", wr_err, 0);
            chk(dn - s == E_REC + 1, "R7 recovery kept", dn - s, E_REC + 1);
        end else begin
            chk(wr_err, "R9 timeout error", wr_err, 1);
            chk(dn - s == E_REC + TMO, "R9 timeout delay", dn - s, E_REC + TMO);
        end
        fb_sts = 1'b1;
        @(negedge clk);
        chk(!wr_done && !wr_err, "R8 done one cycle", wr_done, 0);
        chk(fb_ce_n, "R11 no extra cycle", fb_ce_n, 1);
    endtask

    initial begin
        fork
            begin
                int n;
                repeat (3) @(negedge clk);
                chk(fb_ce_n && fb_we_n, "R1 strobes idle", {fb_ce_n, fb_we_n}, 3);
                chk(!cmd_ready && !wr_done && !wr_err, "R1 flags clear",
                    {cmd_ready, wr_done, wr_err}, 0);
                chk(!fb_dq_oe && !fb_prog_en, "R1 drivers off", {fb_dq_oe, fb_prog_en}, 0);
                rst = 1'b0;
                cmd_valid = 1'b1; cmd_addr = 22'h15; cmd_data = 16'hdead;
                n = 0;
                @(negedge clk);
                chk(!cmd_ready && fb_ce_n, "R1 first cycle", cmd_ready, 0);
                while (!cmd_ready && n < 1000) begin
                    n++;
                    if (n == 50) cmd_valid = 1'b0;
                    if (!fb_ce_n) chk(0, "R2 strobe during boot", 0, 1);
                    @(negedge clk);
                end
                chk(n == E_RST - 1, "R2 boot wait", n + 1, E_RST);
                chk(fb_ce_n, "R2 boot request ignored", fb_ce_n, 1);
                do_write(22'h2a5a5, 16'h1234, 0);
                do_write(22'h3ffff, 16'hffff, 1);
                do_write(22'h00001, 16'h0000, 2);
                do_write(22'h12345, 16'ha5c3, 0);
                repeat (3) @(negedge clk);
                chk(sb_q.size() == 0, "R11 all pulses seen", sb_q.size(), 0);
            end
            begin
                repeat (20000) @(posedge clk);
                chk(0, "watchdog expired", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule